// File: doc/BRIEF.md
# Byte Serializer/Deserializer with Loopback Paths

This block sits between a byte-wide equipment interface and a bit-serial line interface. It runs on one bit-rate clock. A divide-by-8 phase counter produces a transmit byte strobe. The upstream device watches that strobe and presents its next byte on the parallel transmit input. The byte is captured, then shifted out most significant bit first as a continuous stream, with no gap between bytes. In the other direction, line bits are collected into bytes, and each completed byte is announced with a one-cycle valid pulse.

Two independent selects set up the loopback paths for test. The facility select turns the line receive stream straight back onto the line transmit output. The deserializer keeps receiving that stream. The equipment select feeds the serialized transmit stream into the deserializer in place of the line input. The line transmit output keeps carrying that stream. With both selects high, each path applies on its own. Byte alignment to framing patterns is left to a separate block.

Top module: `byte_serdes_loop`

## Requirements
- R1: Outside facility loopback, the byte present on `tx_byte` in a cycle where `tx_byte_strobe` is high is sent on `tx_serial` starting two cycles later, one bit per cycle, bit 7 first and bit 0 last. Consecutive bytes follow with no idle cycle between them.
- R2: `tx_byte_strobe` is high for exactly one cycle in every 8. Counting the first cycle after reset release as cycle 0, it is high in cycles 7, 15, 23 and so on.
- R3: While `fac_loop` is high, `tx_serial` equals `rx_serial` in the same cycle.
- R4: While `fac_loop` is high and `eq_loop` is low, `rx_serial` is still deserialized onto `rx_byte`.
- R5: While `eq_loop` is high, the deserializer takes the serialized transmit stream, and `rx_serial` has no effect on `rx_byte`.
- R6: `rx_byte_valid` is high for one cycle in every 8, two cycles after each `tx_byte_strobe` (cycles 1, 9, 17 and so on). In such a cycle, `rx_byte` holds the deserializer input of the preceding 8 cycles. The earliest of those bits is in bit 7. `rx_byte` holds its value until the next valid cycle.
- R7: While `eq_loop` is high and `fac_loop` is low, `tx_serial` still carries the serialized transmit bytes as in R1.
- R8: With both selects high, `tx_serial` follows `rx_serial` and the deserializer takes the serialized transmit stream.
- R9: A synchronous active-low `rst_n` clears the shift registers, the capture register, `rx_byte`, `rx_byte_valid` and the phase counter. While reset is held, `tx_byte_strobe` is low, and `tx_serial` is low unless facility loopback is selected. After release, the phase restarts as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fac_loop | input | 1 | Line receive stream looped to line transmit |
| eq_loop | input | 1 | Transmit stream looped into the deserializer |
| tx_byte | input | BYTE_W | Parallel transmit byte |
| tx_byte_strobe | output | 1 | Byte request, one cycle in every BYTE_W |
| tx_serial | output | 1 | Line transmit bit |
| rx_serial | input | 1 | Line receive bit |
| rx_byte | output | BYTE_W | Deserialized byte |
| rx_byte_valid | output | 1 | One-cycle pulse when rx_byte is new |

## Verification
The assertions assume that `tx_byte` is stable across the edge that ends a strobe cycle. They also assume that reset is held for at least two cycles, so the two-cycle look-back into the strobe and byte history never reaches back to the values before reset. The bench changes every input just after a rising edge, and only `tx_byte` responds to the strobe. It holds reset for three edges at start-up and again in the middle of the run. Loopback selects are changed at byte boundaries and also mid-byte. Each change of select is followed by a check against a bit-level reference model of the deserializer input.

// File: rtl/byte_serdes_loop.sv
module byte_serdes_loop #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fac_loop,
  input  logic              eq_loop,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              tx_byte_strobe,
  output logic              tx_serial,
  input  logic              rx_serial,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_byte_valid
);
  localparam int CNT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  phase;
  logic [BYTE_W-1:0] tx_hold, tx_shift, rx_shift;
  logic              line_bit, rx_in, load_shift;

  assign tx_byte_strobe = (phase == LAST);
  assign load_shift     = (phase == '0);
  assign line_bit       = tx_shift[BYTE_W-1];
  assign tx_serial      = fac_loop ? rx_serial : line_bit;
  assign rx_in          = eq_loop ? line_bit : rx_serial;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase         <= '0;
      tx_hold       <= '0;
      tx_shift      <= '0;
      rx_shift      <= '0;
      rx_byte       <= '0;
      rx_byte_valid <= 1'b0;
    end else begin
      phase         <= tx_byte_strobe ? '0 : phase + 1'b1;
      if (tx_byte_strobe) tx_hold <= tx_byte;
      tx_shift      <= load_shift ? tx_hold : {tx_shift[BYTE_W-2:0], 1'b0};
      rx_shift      <= {rx_shift[BYTE_W-2:0], rx_in};
      rx_byte_valid <= load_shift;
      if (load_shift) rx_byte <= {rx_shift[BYTE_W-2:0], rx_in};
    end
  end
endmodule

// File: rtl/byte_serdes_loop_chk.sv
module byte_serdes_loop_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fac_loop,
  input logic [BYTE_W-1:0] tx_byte,
  input logic              tx_byte_strobe,
  input logic              tx_serial,
  input logic              rx_serial,
  input logic [BYTE_W-1:0] rx_byte,
  input logic              rx_byte_valid
);
  assert_strobe_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_byte_strobe |=> !tx_byte_strobe);

  assert_msb_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tx_byte_strobe, 2) && !fac_loop) |-> (tx_serial == $past(tx_byte[BYTE_W-1], 2)));

  assert_facility_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fac_loop |-> (tx_serial == rx_serial));

  assert_valid_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_byte_strobe |-> ##2 rx_byte_valid);

  assert_reset_clears_R9: assert property (@(posedge clk)
    !rst_n |=> (rx_byte == '0 && !rx_byte_valid && !tx_byte_strobe));
endmodule

bind byte_serdes_loop byte_serdes_loop_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fac_loop(fac_loop), .tx_byte(tx_byte),
  .tx_byte_strobe(tx_byte_strobe), .tx_serial(tx_serial), .rx_serial(rx_serial),
  .rx_byte(rx_byte), .rx_byte_valid(rx_byte_valid)
);

// File: tb/test_byte_serdes_loop.sv
`timescale 1ns/1ps
module test_byte_serdes_loop;
  localparam int N = 2048;
  // {fac, eq, tx byte offered, rx byte sent MSB first}
  localparam logic [17:0] VEC [14] = '{
    {1'b0, 1'b0, 8'hA5, 8'h3C}, {1'b0, 1'b0, 8'h81, 8'hF0},
    {1'b0, 1'b0, 8'hFF, 8'h00}, {1'b0, 1'b0, 8'h00, 8'hFF},
    {1'b1, 1'b0, 8'h5A, 8'hC3}, {1'b1, 1'b0, 8'h12, 8'h96},
    {1'b1, 1'b0, 8'hE7, 8'h18}, {1'b0, 1'b1, 8'h6B, 8'hFF},
    {1'b0, 1'b1, 8'hD4, 8'h00}, {1'b0, 1'b1, 8'h37, 8'hAA},
    {1'b1, 1'b1, 8'h9C, 8'h55}, {1'b1, 1'b1, 8'h42, 8'hE1},
    {1'b1, 1'b1, 8'hB8, 8'h0F}, {1'b0, 1'b0, 8'h2D, 8'h71}
  };

  logic clk = 0, rst_n = 0, fac_loop = 0, eq_loop = 0, rx_serial = 0;
  logic [7:0] tx_byte = 0;
  logic tx_byte_strobe, tx_serial, rx_byte_valid;
  logic [7:0] rx_byte;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;
  logic exp_tx [N];
  logic rx_in_model [N];
  logic mode_fac [N];
  logic mode_eq [N];

  always #2 clk = ~clk;

  byte_serdes_loop #(.BYTE_W(8)) i_byte_serdes_loop (
    .clk(clk), .rst_n(rst_n), .fac_loop(fac_loop), .eq_loop(eq_loop),
    .tx_byte(tx_byte), .tx_byte_strobe(tx_byte_strobe), .tx_serial(tx_serial),
    .rx_serial(rx_serial), .rx_byte(rx_byte), .rx_byte_valid(rx_byte_valid));

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s cycle %0d actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  task automatic do_reset();
    fac_loop = 0; eq_loop = 0; rx_serial = 0; rst_n = 0;
    for (int i = 0; i < N; i++) begin exp_tx[i] = 0; rx_in_model[i] = 0; mode_fac[i] = 0; mode_eq[i] = 0; end
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(tx_serial == 0 && !tx_byte_strobe && !rx_byte_valid && rx_byte == 0, "R9",
          {tx_serial, tx_byte_strobe, rx_byte_valid, 5'd0} | rx_byte, 8'h00);
    @(posedge clk); #1 rst_n = 1; cyc = 0;
    @(negedge clk);
    check(!tx_byte_strobe && !rx_byte_valid && rx_byte == 0 && tx_serial == 0, "R9",
          {tx_serial, tx_byte_strobe, rx_byte_valid, 5'd0} | rx_byte, 8'h00);
  endtask

  task automatic step(input logic f, input logic e, input logic r, input logic [7:0] nb);
    logic [7:0] exp_rx;
    string tag;
    @(posedge clk); #1;
    cyc++;
    fac_loop = f; eq_loop = e; rx_serial = r;
    mode_fac[cyc] = f; mode_eq[cyc] = e;
    if (tx_byte_strobe) begin
      tx_byte = nb;
      for (int i = 0; i < 8; i++) exp_tx[cyc + 2 + i] = nb[7 - i];
    end
    rx_in_model[cyc] = e ? exp_tx[cyc] : r;
    @(negedge clk);
    check(tx_byte_strobe == (cyc % 8 == 7), "R2", {7'd0, tx_byte_strobe}, {7'd0, cyc % 8 == 7});
    if (f) tag = e ? "R8" : "R3";
    else   tag = e ? "R7" : "R1";
    check(tx_serial == (f ? r : exp_tx[cyc]), tag, {7'd0, tx_serial}, {7'd0, f ? r : exp_tx[cyc]});
    check(rx_byte_valid == (cyc % 8 == 1), "R6", {7'd0, rx_byte_valid}, {7'd0, cyc % 8 == 1});
    if (cyc % 8 == 1 && cyc >= 9) begin
      for (int i = 0; i < 8; i++) exp_rx[7 - i] = rx_in_model[cyc - 8 + i];
      if (mode_eq[cyc - 1]) tag = mode_fac[cyc - 1] ? "R8" : "R5";
      else                  tag = mode_fac[cyc - 1] ? "R4" : "R6";
      check(rx_byte == exp_rx, tag, rx_byte, exp_rx);
    end
  endtask

  initial begin
    logic [7:0] lfsr;
    do_reset();
    for (int k = 0; k < 14; k++)
      for (int b = 0; b < 8; b++)
        step(VEC[k][17], VEC[k][16], VEC[k][7 - b], VEC[k][15:8]);
    // R5: equipment loopback with a toggling line input that must have no effect
    for (int k = 0; k < 24; k++) step(1'b0, 1'b1, k[0], 8'hC9 + 8'(k));
    // mid-byte select changes, R8 and R3 while modes shift
    lfsr = 8'h5B;
    for (int k = 0; k < 40; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(k % 13 > 5, k % 7 > 2, lfsr[0], lfsr);
    end
    // R9: reset in the middle of a stream, phase restarts
    do_reset();
    for (int k = 0; k < 24; k++) step(1'b0, 1'b0, k[1], 8'h3E ^ 8'(k));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule